// File: doc/BRIEF.md
# USB Device Control Register Unit

This unit is the 8-bit control and status register that sits in front of a USB full-speed device core. A processor writes and reads it over a simple register bus. Software uses it to attach or detach the device, to request suspend and resume signalling, to reset the ping-pong buffer selection, and to re-open token processing after a SETUP transaction. The hardware side feeds it a synchronized single-ended-zero indication, a SETUP-received strobe and transaction-complete strobes. It drives the pull-up attach enable, the clock enable of the serial interface engine, the resume drive, the token-processing permit and a bank of ping-pong pointer bits, one for each endpoint and direction.

Each pointer bit selects the odd (1) or even (0) buffer-descriptor bank for its endpoint-direction pair. A completed transaction flips the bit. Turning the module on, or asserting the ping-pong reset control, returns every bit to the even bank. Software must leave suspend before it disables the module. A shutdown that breaks this order is recorded in a sticky error flag.

Top module: `usb_ctl_reg`

## Requirements
- R1: After reset, every stored control bit, every ping-pong pointer bit and the order-error flag are 0, and all four drive outputs are 0.
- R2: The read word has this layout: bit 7 reads 0, bit 6 ping-pong reset, bit 5 single-ended-zero status, bit 4 packet disable, bit 3 module enable, bit 2 resume, bit 1 suspend, bit 0 reads 0. A write stores bits 6, 4, 3, 2 and 1, and the stored value is visible from the next cycle.
- R3: Bit 5 shows the current level of the SE0 input in the same cycle. Writing bit 5 has no effect.
- R4: A SETUP strobe while the module is enabled sets packet disable in the next cycle. The token-processing permit output is 1 only while the module is enabled and packet disable is 0. A software write of 0 to bit 4 clears packet disable.
- R5: When a SETUP strobe and a software write of 0 to bit 4 fall in the same cycle, packet disable ends up 1.
- R6: The attach enable output follows module enable. A write that sets module enable while it was 0 clears every pointer bit in the same clock edge.
- R7: While module enable is 0, the engine clock enable, resume drive and processing permit are 0. Transaction strobes and SETUP strobes change no state.
- R8: A write with bit 6 set clears every pointer bit. While bit 6 stays 1, transaction strobes leave the pointers at 0.
- R9: The engine clock enable is 1 exactly when module enable is 1 and suspend is 0.
- R10: The resume drive output is 1 exactly when module enable and resume are both 1.
- R11: A transaction strobe with endpoint e and direction d (1 = IN) toggles pointer bit 2*e+d in the next cycle, provided module enable is 1 and ping-pong reset is 0. No other pointer bit changes.
- R12: A write that clears module enable while the stored suspend bit is 1 sets the order-error flag, which then stays 1 until reset. Clearing enable while suspend is 0 leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| se0_sync | input | 1 | Synchronized single-ended-zero level |
| setup_stb | input | 1 | SETUP token received, one cycle |
| xfer_done | input | 1 | Transaction complete, one cycle |
| xfer_ep | input | EP_W (4) | Endpoint number of the completed transaction |
| xfer_dir | input | 1 | Direction of the completed transaction, 1 = IN |
| attach_pu_en | output | 1 | Attach pull-up enable |
| sie_clk_en | output | 1 | Serial interface engine clock enable |
| resume_drv | output | 1 | Resume signalling drive |
| pkt_proc_en | output | 1 | Token and packet processing permitted |
| ppb_ptr | output | 2*NUM_EP (32) | Ping-pong pointer bits, index 2*endpoint+direction |
| seq_err | output | 1 | Sticky shutdown-order error |

## Verification
The hardest cases to reach are coincidences within a single cycle. One is a SETUP strobe that arrives in the same cycle as the software write that clears packet disable. Another is a pointer toggle that is ignored because ping-pong reset is held. The bench drives the write strobe and the hardware strobe in the same cycle to produce them. It also reaches the shutdown-order error by first writing enable and suspend together and then clearing enable, and it covers the allowed order as well to show that the flag stays low there.

// File: rtl/usb_ctl_pkg.sv
package usb_ctl_pkg;
   // Bit positions of the control word; software decodes these.
   localparam int unsigned CW_W      = 8;
   localparam int unsigned B_PPBRST  = 6;
   localparam int unsigned B_SE0     = 5;
   localparam int unsigned B_PKTDIS  = 4;
   localparam int unsigned B_EN      = 3;
   localparam int unsigned B_RESUME  = 2;
   localparam int unsigned B_SUSP    = 1;

   typedef struct packed {
      logic ppbrst;
      logic pktdis;
      logic en;
      logic resume;
      logic susp;
   } ctl_t;
endpackage

// File: rtl/usb_ctl_bits.sv
module usb_ctl_bits
   import usb_ctl_pkg::*;
#(
   parameter bit SETUP_WHEN_IDLE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [CW_W-1:0] wdata,
   input  logic            setup_stb,
   output ctl_t            ctl,
   output logic            clr_req,
   output logic            seq_err
);
   ctl_t ctl_q, ctl_d;
   logic err_q;
   logic setup_take;

   generate
      if (SETUP_WHEN_IDLE) begin : g_setup_any
         assign setup_take = setup_stb;
      end else begin : g_setup_en
         assign setup_take = setup_stb & ctl_q.en;
      end
   endgenerate

   always_comb begin
      ctl_d = ctl_q;
      if (wr) begin
         ctl_d.ppbrst = wdata[B_PPBRST];
         ctl_d.pktdis = wdata[B_PKTDIS];
         ctl_d.en     = wdata[B_EN];
         ctl_d.resume = wdata[B_RESUME];
         ctl_d.susp   = wdata[B_SUSP];
      end
      if (setup_take) ctl_d.pktdis = 1'b1;   // hardware set wins
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         err_q <= 1'b0;
      end else begin
         ctl_q <= ctl_d;
         if (wr && ctl_q.en && !wdata[B_EN] && ctl_q.susp) err_q <= 1'b1;
      end
   end

   assign clr_req = wr & (wdata[B_PPBRST] | (wdata[B_EN] & ~ctl_q.en));
   assign ctl     = ctl_q;
   assign seq_err = err_q;

   AST_SETUP_SETS_PKTDIS: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_stb && ctl_q.en) |=> ctl_q.pktdis);  // R4
   AST_SETUP_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_stb && ctl_q.en && wr && !wdata[B_PKTDIS]) |=> ctl_q.pktdis);  // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);  // R12
endmodule

// File: rtl/usb_ctl_ppb.sv
module usb_ctl_ppb #(
   parameter int unsigned NUM_EP = 16,
   localparam int unsigned EP_W  = $clog2(NUM_EP),
   localparam int unsigned NPTR  = 2 * NUM_EP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            hold_clr,
   input  logic            clr_req,
   input  logic            xfer_done,
   input  logic [EP_W-1:0] xfer_ep,
   input  logic            xfer_dir,
   output logic [NPTR-1:0] ptr
);
   logic [EP_W:0] sel_idx;
   logic          tog_ok;

   assign sel_idx = {xfer_ep, xfer_dir};
   assign tog_ok  = xfer_done & en & ~hold_clr;

   for (genvar i = 0; i < NPTR; i++) begin : g_ptr
      localparam logic [EP_W:0] IDX = i[EP_W:0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        ptr[i] <= 1'b0;
         else if (clr_req || hold_clr)      ptr[i] <= 1'b0;
         else if (tog_ok && sel_idx == IDX) ptr[i] <= ~ptr[i];
      end
   end

   AST_HOLD_KEEPS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      hold_clr |=> (ptr == '0));  // R8
   AST_IDLE_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr_req) |=> $stable(ptr));  // R7
   AST_ONE_BIT_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && en && !hold_clr && !clr_req) |=> ($countones(ptr ^ $past(ptr)) == 1));  // R11
endmodule

// File: rtl/usb_ctl_reg.sv
module usb_ctl_reg
   import usb_ctl_pkg::*;
#(
   parameter int unsigned NUM_EP          = 16,
   parameter bit          SETUP_WHEN_IDLE = 1'b0,
   localparam int unsigned EP_W = $clog2(NUM_EP),
   localparam int unsigned NPTR = 2 * NUM_EP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [CW_W-1:0] reg_wdata,
   output logic [CW_W-1:0] reg_rdata,
   input  logic            se0_sync,
   input  logic            setup_stb,
   input  logic            xfer_done,
   input  logic [EP_W-1:0] xfer_ep,
   input  logic            xfer_dir,
   output logic            attach_pu_en,
   output logic            sie_clk_en,
   output logic            resume_drv,
   output logic            pkt_proc_en,
   output logic [NPTR-1:0] ppb_ptr,
   output logic            seq_err
);
   generate
      if (NUM_EP < 2 || NUM_EP > 16) begin : g_bad_ep
         $error("usb_ctl_reg: NUM_EP must lie in 2..16");
      end
      if ((NUM_EP & (NUM_EP - 1)) != 0) begin : g_bad_pow
         $error("usb_ctl_reg: NUM_EP must be a power of two");
      end
   endgenerate

   ctl_t ctl;
   logic clr_req;

   usb_ctl_bits #(.SETUP_WHEN_IDLE(SETUP_WHEN_IDLE)) bits_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .setup_stb(setup_stb), .ctl(ctl), .clr_req(clr_req), .seq_err(seq_err)
   );

   usb_ctl_ppb #(.NUM_EP(NUM_EP)) ppb_i (
      .clk(clk), .rst_n(rst_n), .en(ctl.en), .hold_clr(ctl.ppbrst),
      .clr_req(clr_req), .xfer_done(xfer_done), .xfer_ep(xfer_ep),
      .xfer_dir(xfer_dir), .ptr(ppb_ptr)
   );

   always_comb begin
      reg_rdata           = '0;
      reg_rdata[B_PPBRST] = ctl.ppbrst;
      reg_rdata[B_SE0]    = se0_sync;
      reg_rdata[B_PKTDIS] = ctl.pktdis;
      reg_rdata[B_EN]     = ctl.en;
      reg_rdata[B_RESUME] = ctl.resume;
      reg_rdata[B_SUSP]   = ctl.susp;
   end

   assign attach_pu_en = ctl.en;
   assign sie_clk_en   = ctl.en & ~ctl.susp;
   assign resume_drv   = ctl.en & ctl.resume;
   assign pkt_proc_en  = ctl.en & ~ctl.pktdis;

   AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (reg_rdata[B_EN] == $past(reg_wdata[B_EN])));  // R2
   AST_ENABLE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[B_EN] && !attach_pu_en) |=> (ppb_ptr == '0));  // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !attach_pu_en |-> !(sie_clk_en || resume_drv || pkt_proc_en));  // R7
endmodule

// File: tb/usb_ctl_reg_tb_top.sv
module usb_ctl_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        se0_sync = 1'b0;
   logic        setup_stb = 1'b0;
   logic        xfer_done = 1'b0;
   logic [3:0]  xfer_ep = '0;
   logic        xfer_dir = 1'b0;
   logic        attach_pu_en, sie_clk_en, resume_drv, pkt_proc_en, seq_err;
   logic [31:0] ppb_ptr;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   usb_ctl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .se0_sync(se0_sync), .setup_stb(setup_stb),
      .xfer_done(xfer_done), .xfer_ep(xfer_ep), .xfer_dir(xfer_dir),
      .attach_pu_en(attach_pu_en), .sie_clk_en(sie_clk_en),
      .resume_drv(resume_drv), .pkt_proc_en(pkt_proc_en),
      .ppb_ptr(ppb_ptr), .seq_err(seq_err)
   );

   // {wdata[8], se0, expected rdata[8], expected {attach, sieclk, resume, permit}}
   localparam int NV = 8;
   localparam logic [20:0] VEC [NV] = '{
      {8'h08, 1'b0, 8'h08, 4'b1101},
      {8'h0A, 1'b1, 8'h2A, 4'b1001},
      {8'h0C, 1'b0, 8'h0C, 4'b1111},
      {8'h2C, 1'b0, 8'h0C, 4'b1111},
      {8'h1C, 1'b1, 8'h3C, 4'b1110},
      {8'h81, 1'b0, 8'h00, 4'b0000},
      {8'h06, 1'b0, 8'h06, 4'b0000},
      {8'h08, 1'b0, 8'h08, 4'b1101}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock: drive at the current point, capture at the edge, settle 2 ns after it.
   task automatic step(input logic wr, input logic [7:0] wd, input logic stp,
                       input logic xd, input logic [3:0] ep, input logic dir);
      reg_wr = wr; reg_wdata = wd; setup_stb = stp;
      xfer_done = xd; xfer_ep = ep; xfer_dir = dir;
      @(posedge clk);
      #2;
      reg_wr = 1'b0; setup_stb = 1'b0; xfer_done = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] wd);
      step(1'b1, wd, 1'b0, 1'b0, 4'd0, 1'b0);
   endtask

   task automatic xfer(input logic [3:0] ep, input logic dir);
      step(1'b0, 8'h00, 1'b0, 1'b1, ep, dir);
   endtask

   function automatic logic [3:0] outs();
      return {attach_pu_en, sie_clk_en, resume_drv, pkt_proc_en};
   endfunction

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk("R1 rdata", {24'd0, reg_rdata}, 32'h00);
      chk("R1 outs", {28'd0, outs()}, 32'h0);
      chk("R1 ppb", ppb_ptr, 32'h0);
      chk("R1 err", {31'd0, seq_err}, 32'h0);
      rst_n = 1'b1;
      @(posedge clk); #2;

      // R2 R3 R9 R10 R4 R7: table walk
      for (int i = 0; i < NV; i++) begin
         se0_sync = VEC[i][12];
         wr_reg(VEC[i][20:13]);
         chk($sformatf("R2/R3/R9/R10 vec%0d rdata", i), {24'd0, reg_rdata}, {24'd0, VEC[i][11:4]});
         chk($sformatf("R7/R9/R10 vec%0d outs", i), {28'd0, outs()}, {28'd0, VEC[i][3:0]});
      end
      se0_sync = 1'b0;
      chk("R12 no err on allowed shutdown", {31'd0, seq_err}, 32'h0);

      // R3: SE0 status is live in the same cycle
      se0_sync = 1'b1; #1;
      chk("R3 se0 live", {24'd0, reg_rdata}, 32'h28);
      se0_sync = 1'b0; #1;

      // R11: pointer toggles
      xfer(4'd3, 1'b1);
      chk("R11 ep3 in", ppb_ptr, 32'h1 << 7);
      xfer(4'd15, 1'b0);
      chk("R11 ep15 out", ppb_ptr, (32'h1 << 7) | (32'h1 << 30));
      xfer(4'd3, 1'b1);
      chk("R11 ep3 in back", ppb_ptr, 32'h1 << 30);

      // R8: ping-pong reset clears and holds
      wr_reg(8'h48);
      chk("R8 clear", ppb_ptr, 32'h0);
      xfer(4'd5, 1'b0);
      chk("R8 hold", ppb_ptr, 32'h0);
      wr_reg(8'h08);
      xfer(4'd0, 1'b0);
      chk("R11 ep0 out", ppb_ptr, 32'h1);

      // R7: disabled ignores strobes
      wr_reg(8'h00);
      xfer(4'd1, 1'b1);
      chk("R7 xfer ignored", ppb_ptr, 32'h1);
      step(1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 1'b0);
      chk("R7 setup ignored", {24'd0, reg_rdata}, 32'h00);

      // R6: enable clears pointers
      wr_reg(8'h08);
      chk("R6 enable clears", ppb_ptr, 32'h0);
      chk("R6 attach", {31'd0, attach_pu_en}, 32'h1);

      // R4: SETUP sets packet disable, software clears
      step(1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 1'b0);
      chk("R4 setup sets", {24'd0, reg_rdata}, 32'h18);
      chk("R4 permit off", {31'd0, pkt_proc_en}, 32'h0);
      wr_reg(8'h08);
      chk("R4 sw clear", {24'd0, reg_rdata}, 32'h08);

      // R5: same-cycle SETUP and clear
      wr_reg(8'h18);
      step(1'b1, 8'h08, 1'b1, 1'b0, 4'd0, 1'b0);
      chk("R5 hw wins", {24'd0, reg_rdata}, 32'h18);
      wr_reg(8'h08);

      // R12: disallowed shutdown order
      wr_reg(8'h0A);
      chk("R12 before", {31'd0, seq_err}, 32'h0);
      wr_reg(8'h00);
      chk("R12 set", {31'd0, seq_err}, 32'h1);
      wr_reg(8'h08);
      chk("R12 sticky", {31'd0, seq_err}, 32'h1);

      // R1: reset again
      rst_n = 1'b0; #3;
      chk("R1 re-reset err", {31'd0, seq_err}, 32'h0);
      chk("R1 re-reset rdata", {24'd0, reg_rdata}, 32'h00);
      rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule